// File: doc/BRIEF.md
# Shared Multi-Thread Reorder Buffer

This block is one circular reorder buffer whose entries are shared by several hardware threads. A thread's instructions need not sit in adjacent entries. Each entry carries the ID of its owning thread and a link to the next entry of the same thread. The block keeps a head, a tail and an occupancy count for each thread. One dispatch port takes a thread ID and a payload and returns the index of the entry it allocated. One completion port marks an entry finished by its index. A commit stage per thread retires that thread's oldest entry once it is finished.

Two outside inputs bound where dispatch may go. The first is a per-thread entry cap, which an outside partitioning policy can raise above an equal share. The second is a per-bank enable mask: it stops new dispatches into banks that are being powered down, while entries already in those banks drain normally. The block reports occupancy per thread and per bank. It also flags every bank that holds some thread's head or tail, so a power controller can judge how soon a bank will empty.

Top module: `shared_rob`

## Requirements
- R1: After reset, every thread and bank count reads 0, no commit is presented, no bank is flagged as holding a head or tail, and a thread with a nonzero cap that dispatches is given entry 0.
- R2: A dispatch takes the first entry that is free and lies in an enabled bank. The scan runs upward with wraparound, starting at the entry just after that thread's most recently dispatched entry (entry 0 if the thread has not dispatched since reset). `disp_idx` shows that entry.
- R3: `disp_ready` is low whenever the selected thread's occupancy is equal to or above its cap.
- R4: `disp_ready` is low when no free entry exists in any enabled bank.
- R5: Entry i belongs to bank i / (DEPTH/NBANKS), and bit b of `bank_en` enables bank b. No entry in a disabled bank is ever dispatched into. Entries already in a disabled bank still complete and commit.
- R6: A completion aimed at an entry that is free or already finished has no effect. A later dispatch into that entry still waits for its own completion.
- R7: At a clock edge where a thread's oldest entry is finished, the following cycle presents `cmt_valid`, `cmt_idx` and `cmt_payload` for that thread. A thread retires at most one entry per cycle, and a finished younger entry waits until every older entry has retired.
- R8: Threads commit independently. Several threads may retire in the same cycle.
- R9: `thr_occ` for a thread equals the number of entries it has dispatched and not yet retired, and is updated at the same edge as the dispatch or retirement.
- R10: `bank_occ` for a bank equals the number of occupied entries in that bank, and is updated at the same edge as the dispatch or retirement.
- R11: `bank_head_in[b]` is set exactly when some non-empty thread has its oldest entry in bank b. `bank_tail_in[b]` is set exactly when some non-empty thread has its newest entry in bank b.
- R12: Retirement follows each thread's dispatch order, even when that thread's entries are scattered and interleaved with other threads' entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_en | input | NBANKS | Per-bank dispatch enable |
| thr_cap | input | NTHREADS x CNT_W | Per-thread entry cap |
| disp_valid | input | 1 | Dispatch request |
| disp_tid | input | TID_W | Thread of the dispatch |
| disp_payload | input | PAY_W | Data stored with the entry |
| disp_ready | output | 1 | Dispatch accepted this cycle |
| disp_idx | output | IDX_W | Entry chosen for the dispatch |
| cmpl_valid | input | 1 | Completion request |
| cmpl_idx | input | IDX_W | Entry being marked finished |
| cmt_valid | output | NTHREADS | Per-thread retirement strobe |
| cmt_idx | output | NTHREADS x IDX_W | Retired entry per thread |
| cmt_payload | output | NTHREADS x PAY_W | Retired payload per thread |
| thr_occ | output | NTHREADS x CNT_W | Per-thread occupancy |
| bank_occ | output | NBANKS x BCNT_W | Per-bank occupancy |
| bank_head_in | output | NBANKS | Some thread's head lies in this bank |
| bank_tail_in | output | NBANKS | Some thread's tail lies in this bank |

## Verification
The bench builds the block with two threads, eight entries and four banks of two entries each. At that size, entries from the two threads interleave within a few cycles, so wraparound and the tail-relative scan start occur often. The bench sweeps all sixteen bank-enable masks, including the all-disabled case, and four cap pairs ranging from a cap of one to the full buffer. This drives every stall cause and every head and tail flag position. A small arithmetic model of per-entry state and per-thread order queues predicts each output cycle by cycle.

// File: rtl/srob_pkg.sv
package srob_pkg;

  // Life cycle of one buffer entry.
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_DONE = 2'd2
  } slot_e;

endpackage

// File: rtl/srob_free_pick.sv
// Circular search for the first free entry in an enabled bank,
// starting at a given index.
module srob_free_pick #(
  parameter int DEPTH  = 64,
  parameter int NBANKS = 8,
  parameter int IDX_W  = 6
) (
  input  logic [DEPTH-1:0]  free_vec,
  input  logic [NBANKS-1:0] bank_en,
  input  logic [IDX_W-1:0]  start,
  output logic              found,
  output logic [IDX_W-1:0]  pick
);
  localparam int BANK_SZ = DEPTH / NBANKS;

  logic [DEPTH-1:0] avail;

  for (genvar e = 0; e < DEPTH; e++) begin : g_avail
    assign avail[e] = free_vec[e] & bank_en[e / BANK_SZ];
  end

  // Walk from the far end back to the start so the nearest hit wins.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      int j;
      j = (int'(start) + k) % DEPTH;
      if (avail[j]) begin
        found = 1'b1;
        pick  = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/srob_thread_ptr.sv
// Head, tail and occupancy for one thread.
module srob_thread_ptr #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             disp_fire,
  input  logic [IDX_W-1:0] disp_idx,
  input  logic             cmt_fire,
  input  logic [IDX_W-1:0] link_at_head,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] cnt,
  output logic             link_we
);
  localparam logic [IDX_W-1:0] TAIL_RST = IDX_W'(DEPTH - 1);

  // The old tail gets a link only if it stays occupied across this edge.
  assign link_we = disp_fire &&
                   ((cnt > CNT_W'(1)) || ((cnt == CNT_W'(1)) && !cmt_fire));

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= TAIL_RST;
      cnt  <= '0;
    end else begin
      case ({disp_fire, cmt_fire})
        2'b10: begin
          tail <= disp_idx;
          if (cnt == '0) head <= disp_idx;
          cnt <= cnt + CNT_W'(1);
        end
        2'b01: begin
          head <= link_at_head;
          cnt  <= cnt - CNT_W'(1);
        end
        2'b11: begin
          tail <= disp_idx;
          head <= (cnt == CNT_W'(1)) ? disp_idx : link_at_head;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/srob_bank_stat.sv
// Per-bank occupancy counters and head/tail presence flags.
module srob_bank_stat #(
  parameter int DEPTH    = 64,
  parameter int NBANKS   = 8,
  parameter int NTHREADS = 4,
  parameter int IDX_W    = 6,
  parameter int BCNT_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            disp_fire,
  input  logic [IDX_W-1:0]                disp_idx,
  input  logic [NTHREADS-1:0]             cmt_fire,
  input  logic [NTHREADS-1:0]             nonempty,
  input  logic [NTHREADS-1:0][IDX_W-1:0]  head,
  input  logic [NTHREADS-1:0][IDX_W-1:0]  tail,
  output logic [NBANKS-1:0][BCNT_W-1:0]   bank_occ,
  output logic [NBANKS-1:0]               head_in,
  output logic [NBANKS-1:0]               tail_in
);
  localparam int BANK_SZ = DEPTH / NBANKS;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic              inc;
    logic [BCNT_W-1:0] dec;
    logic [BCNT_W-1:0] occ_q;
    logic              hf, tf;

    always_comb begin
      inc = disp_fire && ((int'(disp_idx) / BANK_SZ) == b);
      dec = '0;
      hf  = 1'b0;
      tf  = 1'b0;
      for (int t = 0; t < NTHREADS; t++) begin
        if (cmt_fire[t] && ((int'(head[t]) / BANK_SZ) == b)) dec = dec + BCNT_W'(1);
        if (nonempty[t] && ((int'(head[t]) / BANK_SZ) == b)) hf = 1'b1;
        if (nonempty[t] && ((int'(tail[t]) / BANK_SZ) == b)) tf = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) occ_q <= '0;
      else     occ_q <= occ_q + BCNT_W'(inc) - dec;
    end

    assign bank_occ[b] = occ_q;
    assign head_in[b]  = hf;
    assign tail_in[b]  = tf;
  end

endmodule

// File: rtl/shared_rob.sv
// Reorder buffer shared by several threads, with linked per-thread order.
module shared_rob
  import srob_pkg::*;
#(
  parameter int  NTHREADS = 4,
  parameter int  DEPTH    = 64,
  parameter int  NBANKS   = 8,
  parameter int  PAY_W    = 32,
  localparam int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int BCNT_W   = $clog2((DEPTH / NBANKS) + 1)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NBANKS-1:0]                bank_en,
  input  logic [NTHREADS-1:0][CNT_W-1:0]   thr_cap,
  input  logic                             disp_valid,
  input  logic [TID_W-1:0]                 disp_tid,
  input  logic [PAY_W-1:0]                 disp_payload,
  output logic                             disp_ready,
  output logic [IDX_W-1:0]                 disp_idx,
  input  logic                             cmpl_valid,
  input  logic [IDX_W-1:0]                 cmpl_idx,
  output logic [NTHREADS-1:0]              cmt_valid,
  output logic [NTHREADS-1:0][IDX_W-1:0]   cmt_idx,
  output logic [NTHREADS-1:0][PAY_W-1:0]   cmt_payload,
  output logic [NTHREADS-1:0][CNT_W-1:0]   thr_occ,
  output logic [NBANKS-1:0][BCNT_W-1:0]    bank_occ,
  output logic [NBANKS-1:0]                bank_head_in,
  output logic [NBANKS-1:0]                bank_tail_in
);
  // Entry state (reset) and entry storage (no reset, RAM-friendly).
  slot_e            slot_q   [DEPTH];
  logic [TID_W-1:0] owner_q  [DEPTH];
  logic [PAY_W-1:0] pay_mem  [DEPTH];
  logic [IDX_W-1:0] link_mem [DEPTH];

  logic [DEPTH-1:0] free_vec;
  logic [DEPTH-1:0] occ_vec;

  logic [NTHREADS-1:0][IDX_W-1:0] head_w;
  logic [NTHREADS-1:0][IDX_W-1:0] tail_w;
  logic [NTHREADS-1:0][CNT_W-1:0] cnt_w;
  logic [NTHREADS-1:0][IDX_W-1:0] link_at_head;
  logic [NTHREADS-1:0]            link_we;
  logic [NTHREADS-1:0]            cmt_go;
  logic [NTHREADS-1:0]            nonempty;
  logic [NTHREADS-1:0]            disp_sel;

  logic             tid_ok;
  logic [CNT_W-1:0] cap_sel;
  logic [CNT_W-1:0] cnt_sel;
  logic [IDX_W-1:0] tail_sel;
  logic [IDX_W-1:0] start_idx;
  logic             slot_found;
  logic [IDX_W-1:0] slot_pick;
  logic             disp_fire;
  logic             cmpl_in_range;

  for (genvar e = 0; e < DEPTH; e++) begin : g_free
    assign free_vec[e] = (slot_q[e] == SLOT_FREE);
  end
  assign occ_vec = ~free_vec;

  // Select the requesting thread's limits and tail.
  always_comb begin
    tid_ok   = 1'b0;
    cap_sel  = '0;
    cnt_sel  = '0;
    tail_sel = '0;
    disp_sel = '0;
    for (int t = 0; t < NTHREADS; t++) begin
      if (int'(disp_tid) == t) begin
        tid_ok      = 1'b1;
        cap_sel     = thr_cap[t];
        cnt_sel     = cnt_w[t];
        tail_sel    = tail_w[t];
        disp_sel[t] = 1'b1;
      end
    end
  end

  assign start_idx = (tail_sel == IDX_W'(DEPTH - 1)) ? '0 : tail_sel + IDX_W'(1);

  srob_free_pick #(
    .DEPTH (DEPTH),
    .NBANKS(NBANKS),
    .IDX_W (IDX_W)
  ) u_pick (
    .free_vec(free_vec),
    .bank_en (bank_en),
    .start   (start_idx),
    .found   (slot_found),
    .pick    (slot_pick)
  );

  assign disp_ready    = tid_ok && slot_found && (cnt_sel < cap_sel);
  assign disp_idx      = slot_pick;
  assign disp_fire     = disp_valid && disp_ready;
  assign cmpl_in_range = (int'(cmpl_idx) < DEPTH);

  // Per-thread pointers and retirement decision.
  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    assign nonempty[t]     = (cnt_w[t] != '0);
    assign link_at_head[t] = link_mem[head_w[t]];
    assign cmt_go[t]       = nonempty[t] &&
                             (slot_q[head_w[t]] == SLOT_DONE) &&
                             (owner_q[head_w[t]] == TID_W'(t));

    srob_thread_ptr #(
      .DEPTH(DEPTH),
      .IDX_W(IDX_W),
      .CNT_W(CNT_W)
    ) u_ptr (
      .clk         (clk),
      .rst         (rst),
      .disp_fire   (disp_fire && disp_sel[t]),
      .disp_idx    (slot_pick),
      .cmt_fire    (cmt_go[t]),
      .link_at_head(link_at_head[t]),
      .head        (head_w[t]),
      .tail        (tail_w[t]),
      .cnt         (cnt_w[t]),
      .link_we     (link_we[t])
    );

    assign thr_occ[t] = cnt_w[t];
  end

  // Entry state machine: commit frees, completion finishes, dispatch claims.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) slot_q[e] <= SLOT_FREE;
    end else begin
      for (int t = 0; t < NTHREADS; t++) begin
        if (cmt_go[t]) slot_q[head_w[t]] <= SLOT_FREE;
      end
      if (cmpl_valid && cmpl_in_range && (slot_q[cmpl_idx] == SLOT_PEND))
        slot_q[cmpl_idx] <= SLOT_DONE;
      if (disp_fire) slot_q[slot_pick] <= SLOT_PEND;
    end
  end

  // Entry storage written only on dispatch.
  always_ff @(posedge clk) begin
    if (disp_fire) begin
      pay_mem[slot_pick] <= disp_payload;
      owner_q[slot_pick] <= disp_tid;
    end
    for (int t = 0; t < NTHREADS; t++) begin
      if (link_we[t]) link_mem[tail_w[t]] <= slot_pick;
    end
  end

  // Registered retirement outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_valid   <= '0;
      cmt_idx     <= '0;
      cmt_payload <= '0;
    end else begin
      cmt_valid <= cmt_go;
      for (int t = 0; t < NTHREADS; t++) begin
        cmt_idx[t]     <= head_w[t];
        cmt_payload[t] <= pay_mem[head_w[t]];
      end
    end
  end

  srob_bank_stat #(
    .DEPTH   (DEPTH),
    .NBANKS  (NBANKS),
    .NTHREADS(NTHREADS),
    .IDX_W   (IDX_W),
    .BCNT_W  (BCNT_W)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .disp_fire(disp_fire),
    .disp_idx (slot_pick),
    .cmt_fire (cmt_go),
    .nonempty (nonempty),
    .head     (head_w),
    .tail     (tail_w),
    .bank_occ (bank_occ),
    .head_in  (bank_head_in),
    .tail_in  (bank_tail_in)
  );

endmodule

// File: rtl/srob_checker.sv
// Property checks for the shared reorder buffer.
module srob_checker #(
  parameter int  NTHREADS = 4,
  parameter int  DEPTH    = 64,
  parameter int  NBANKS   = 8,
  localparam int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
  localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int BCNT_W   = $clog2((DEPTH / NBANKS) + 1),
  localparam int BANK_SZ  = DEPTH / NBANKS
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NBANKS-1:0]              bank_en,
  input logic [NTHREADS-1:0][CNT_W-1:0] thr_cap,
  input logic                           disp_valid,
  input logic [TID_W-1:0]               disp_tid,
  input logic                           disp_ready,
  input logic [IDX_W-1:0]               disp_idx,
  input logic [NTHREADS-1:0]            cmt_valid,
  input logic [NTHREADS-1:0][CNT_W-1:0] thr_occ,
  input logic [NBANKS-1:0][BCNT_W-1:0]  bank_occ,
  input logic [DEPTH-1:0]               occ_vec
);
  int thr_sum;
  int bank_sum;

  always_comb begin
    thr_sum  = 0;
    bank_sum = 0;
    for (int t = 0; t < NTHREADS; t++) thr_sum = thr_sum + int'(thr_occ[t]);
    for (int b = 0; b < NBANKS; b++) bank_sum = bank_sum + int'(bank_occ[b]);
  end

  // R5: a granted dispatch lands in an enabled bank.
  p_bank_enabled_r5: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready) |-> bank_en[int'(disp_idx) / BANK_SZ]);

  // R2: a granted dispatch targets an unoccupied entry.
  p_free_target_r2: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && disp_ready) |-> !occ_vec[disp_idx]);

  // R10: thread counts, bank counts and entry states agree.
  always_ff @(posedge clk) begin
    if (!rst) begin
      p_count_agree_r10: assert ((thr_sum == bank_sum) && (bank_sum == $countones(occ_vec)));
    end
  end

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    // R3: occupancy grows only from below the cap.
    p_cap_respected_r3: assert property (@(posedge clk) disable iff (rst)
      (thr_occ[t] > $past(thr_occ[t])) |-> ($past(thr_occ[t]) < $past(thr_cap[t])));

    // R9: occupancy moves by at most one per cycle.
    p_occ_step_r9: assert property (@(posedge clk) disable iff (rst)
      (int'(thr_occ[t]) <= int'($past(thr_occ[t])) + 1) &&
      (int'(thr_occ[t]) + 1 >= int'($past(thr_occ[t]))));

    // R7: a retirement needs a previously non-empty thread.
    p_commit_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
      cmt_valid[t] |-> ($past(thr_occ[t]) != '0));
  end

endmodule

bind shared_rob srob_checker #(
  .NTHREADS(NTHREADS),
  .DEPTH   (DEPTH),
  .NBANKS  (NBANKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bank_en   (bank_en),
  .thr_cap   (thr_cap),
  .disp_valid(disp_valid),
  .disp_tid  (disp_tid),
  .disp_ready(disp_ready),
  .disp_idx  (disp_idx),
  .cmt_valid (cmt_valid),
  .thr_occ   (thr_occ),
  .bank_occ  (bank_occ),
  .occ_vec   (occ_vec)
);

// File: tb/shared_rob_test.sv
module shared_rob_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2;
  localparam int D  = 8;
  localparam int NB = 4;
  localparam int PW = 8;
  localparam int TW = 1;
  localparam int IW = 3;
  localparam int CW = 4;
  localparam int BW = 2;
  localparam int BS = D / NB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NB-1:0]          bank_en = '1;
  logic [NT-1:0][CW-1:0]  thr_cap;
  logic                   disp_valid = 1'b0;
  logic [TW-1:0]          disp_tid = '0;
  logic [PW-1:0]          disp_payload = '0;
  logic                   disp_ready;
  logic [IW-1:0]          disp_idx;
  logic                   cmpl_valid = 1'b0;
  logic [IW-1:0]          cmpl_idx = '0;
  logic [NT-1:0]          cmt_valid;
  logic [NT-1:0][IW-1:0]  cmt_idx;
  logic [NT-1:0][PW-1:0]  cmt_payload;
  logic [NT-1:0][CW-1:0]  thr_occ;
  logic [NB-1:0][BW-1:0]  bank_occ;
  logic [NB-1:0]          bank_head_in;
  logic [NB-1:0]          bank_tail_in;

  always #(CLK_PERIOD / 2) clk = ~clk;

  shared_rob #(.NTHREADS(NT), .DEPTH(D), .NBANKS(NB), .PAY_W(PW)) uut (
    .clk(clk), .rst(rst), .bank_en(bank_en), .thr_cap(thr_cap),
    .disp_valid(disp_valid), .disp_tid(disp_tid), .disp_payload(disp_payload),
    .disp_ready(disp_ready), .disp_idx(disp_idx),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
    .cmt_valid(cmt_valid), .cmt_idx(cmt_idx), .cmt_payload(cmt_payload),
    .thr_occ(thr_occ), .bank_occ(bank_occ),
    .bank_head_in(bank_head_in), .bank_tail_in(bank_tail_in)
  );

  // Model: entry state 0 free, 1 pending, 2 finished; per-thread order rings.
  int mst [D];
  int mpay [D];
  int mring [NT][D];
  int mrd [NT];
  int mcnt [NT];
  int mtail [NT];
  int ecv [NT];
  int eci [NT];
  int ecp [NT];
  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] seed = 32'h1ACE_B00C;

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int e = 0; e < D; e++) begin mst[e] = 0; mpay[e] = 0; end
    for (int t = 0; t < NT; t++) begin
      mrd[t] = 0; mcnt[t] = 0; mtail[t] = D - 1;
      ecv[t] = 0; eci[t] = 0; ecp[t] = 0;
    end
  endtask

  // Registered outputs against the model after an edge.
  task automatic check_regs();
    for (int t = 0; t < NT; t++) begin
      chk((ecv[0] != 0 && ecv[1] != 0) ? "R8 commit valid" : "R7 commit valid",
          int'(cmt_valid[t]), ecv[t]);
      if (ecv[t] != 0) begin
        chk("R12 commit index", int'(cmt_idx[t]), eci[t]);
        chk("R7 commit payload", int'(cmt_payload[t]), ecp[t]);
      end
      chk("R9 thread occupancy", int'(thr_occ[t]), mcnt[t]);
    end
    for (int b = 0; b < NB; b++) begin
      int occ;
      int hf;
      int tf;
      occ = 0; hf = 0; tf = 0;
      for (int e = b * BS; e < (b + 1) * BS; e++) if (mst[e] != 0) occ++;
      for (int t = 0; t < NT; t++) begin
        if (mcnt[t] > 0 && (mring[t][mrd[t]] / BS) == b) hf = 1;
        if (mcnt[t] > 0 && (mtail[t] / BS) == b) tf = 1;
      end
      chk("R10 bank occupancy", int'(bank_occ[b]), occ);
      chk("R11 head flag", int'(bank_head_in[b]), hf);
      chk("R11 tail flag", int'(bank_tail_in[b]), tf);
    end
  endtask

  // Drive one cycle of stimulus, check the handshake, advance the model.
  task automatic step(input bit dv, input int tid, input int pay, input bit cv, input int ci);
    int start;
    int pick;
    bit found;
    bit ok;
    bit fire;
    int go [NT];
    disp_valid   = dv;
    disp_tid     = TW'(tid);
    disp_payload = PW'(pay);
    cmpl_valid   = cv;
    cmpl_idx     = IW'(ci);
    #1;
    start = (mtail[tid] + 1) % D;
    found = 1'b0;
    pick  = 0;
    for (int k = 0; k < D; k++) begin
      int j;
      j = (start + k) % D;
      if (!found && mst[j] == 0 && bank_en[j / BS]) begin found = 1'b1; pick = j; end
    end
    ok = (mcnt[tid] < int'(thr_cap[tid])) && found;
    if (mcnt[tid] >= int'(thr_cap[tid])) chk("R3 cap stall", int'(disp_ready), 0);
    else if (!found)                     chk("R4 no-room stall", int'(disp_ready), 0);
    else                                 chk("R2 ready", int'(disp_ready), 1);
    if (ok) begin
      chk("R2 chosen entry", int'(disp_idx), pick);
      chk("R5 chosen bank enabled", int'(bank_en[int'(disp_idx) / BS]), 1);
    end
    fire = dv && ok;
    for (int t = 0; t < NT; t++) begin
      go[t] = (mcnt[t] > 0 && mst[mring[t][mrd[t]]] == 2) ? 1 : 0;
      ecv[t] = go[t];
      if (go[t] != 0) begin
        eci[t] = mring[t][mrd[t]];
        ecp[t] = mpay[eci[t]];
      end
    end
    begin
      bit ce;
      ce = cv && (mst[ci] == 1);
      for (int t = 0; t < NT; t++) begin
        if (go[t] != 0) begin
          mst[mring[t][mrd[t]]] = 0;
          mrd[t] = (mrd[t] + 1) % D;
          mcnt[t]--;
        end
      end
      if (ce) mst[ci] = 2;
    end
    if (fire) begin
      mst[pick]  = 1;
      mpay[pick] = pay % 256;
      mring[tid][(mrd[tid] + mcnt[tid]) % D] = pick;
      mcnt[tid]++;
      mtail[tid] = pick;
    end
    @(posedge clk);
    @(negedge clk);
    check_regs();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    finish_run();
  end

  initial begin
    thr_cap[0] = CW'(D);
    thr_cap[1] = CW'(D);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    #1;
    // R1: state straight out of reset.
    for (int t = 0; t < NT; t++) begin
      chk("R1 occupancy", int'(thr_occ[t]), 0);
      chk("R1 commit idle", int'(cmt_valid[t]), 0);
    end
    chk("R1 bank counts", int'(bank_occ), 0);
    chk("R1 head flags", int'(bank_head_in), 0);
    chk("R1 tail flags", int'(bank_tail_in), 0);
    chk("R1 ready", int'(disp_ready), 1);
    chk("R1 first entry", int'(disp_idx), 0);

    // R6: completing a free entry leaves no trace.
    step(1'b0, 0, 0, 1'b1, 2);
    step(1'b1, 0, 8'h11, 1'b0, 0);
    step(1'b1, 0, 8'h22, 1'b0, 0);
    step(1'b1, 0, 8'h33, 1'b0, 0);
    step(1'b0, 0, 0, 1'b0, 0);
    step(1'b0, 0, 0, 1'b0, 0);
    chk("R6 no stray commit", int'(cmt_valid[0]), 0);
    chk("R6 entries kept", int'(thr_occ[0]), 3);

    // R12 and R8: interleaved threads, completion out of order.
    step(1'b1, 1, 8'h44, 1'b1, 2);
    step(1'b1, 1, 8'h55, 1'b1, 1);
    step(1'b1, 0, 8'h66, 1'b1, 4);
    step(1'b0, 0, 0, 1'b1, 0);
    step(1'b0, 0, 0, 1'b1, 3);
    step(1'b0, 0, 0, 1'b1, 5);
    for (int i = 0; i < 6; i++) step(1'b0, 0, 0, 1'b0, 0);

    // Sweep every bank mask under several cap pairs.
    for (int mask = 0; mask < (1 << NB); mask++) begin
      for (int cs = 0; cs < 4; cs++) begin
        bank_en    = NB'(mask);
        thr_cap[0] = CW'(1 << cs);
        thr_cap[1] = CW'(D - 2 * cs);
        for (int i = 0; i < 30; i++) begin
          int unsigned r;
          r = rnd();
          step((r % 10) < 6, int'((r >> 4) % NT), int'((r >> 8) % 256),
               ((r >> 16) % 4) != 0, int'((r >> 20) % D));
        end
      end
    end
    bank_en = '1;
    for (int i = 0; i < 40; i++) step(1'b0, 0, 0, 1'b1, i % D);

    finish_run();
  end

endmodule